// File: doc/BRIEF.md
# GPIO Output and Direction Register Block with Atomic Bit Aliases

This block is the register-bus face of two banks of general-purpose pins. Each bank holds a pin level register (the value each pin drives) and a direction register (1 makes the pin an output, 0 leaves it an input). It also samples the pin inputs through a two-flop synchroniser into a read-only sample register. Software can load either register with a plain write. It can also change selected bits of either register with one write to a set, clear or toggle alias address. These aliases remove the read-modify-write race when several agents share one bank.

The lower bank is fully populated. The upper bank uses the same address scheme but only some bits exist: a group of general pins at the bottom, four single special pins at bits 24 to 27, and a 4-bit data group at bits 28 to 31. Bits that do not exist read as zero and cannot be set.

Top module: `gpio_alias_top`

## Requirements
- R1: While reset is asserted, the level and direction registers of both banks, and every pin_out and pin_oe bit, are zero.
- R2: The word address is decoded as bit 4 = bank (0 lower, 1 upper), bit 3 = register (0 level, 1 direction), bits [2:0] = operation (0 direct, 1 set, 2 clear, 3 toggle, 4 input sample). A direct write (operation 0) loads the level register, which drives pin_out. A direct read returns the current register value.
- R3: A direct write to the direction register loads it and drives pin_oe. A 1 bit makes that pin an output.
- R4: A write to a set alias ORs the write data into the target register. Bits written as 0 are unchanged.
- R5: A write to a clear alias forces to 0 every target bit written as 1. Bits written as 0 are unchanged.
- R6: A write to a toggle alias inverts every target bit written as 1. Bits written as 0 are unchanged.
- R7: Reads of the set, clear and toggle aliases (operations 1 to 3) return zero.
- R8: A read of operation 4 with register bit 0 returns the bank's pin inputs after a two-flop synchroniser. A pin change made before clock edge k appears after edge k+1 and not after edge k. Writes to that address change nothing.
- R9: In the upper bank only bits [15:0], 24 to 27 and [31:28] exist. Bits 16 to 23 of its registers, pin_out_hi, pin_oe_hi and its sample reads are always zero.
- R10: Alias writes update the register on the same clock edge as a direct write. Alias writes on consecutive cycles each take effect in turn.
- R11: A cycle with bus_we low, or a write to operations 5 to 7, or to operation 4 with register bit 1, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Word address: bank, register, operation |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in_lo | input | 32 | Lower bank pin inputs |
| pin_out_lo | output | 32 | Lower bank pin levels |
| pin_oe_lo | output | 32 | Lower bank output enables |
| pin_in_hi | input | 32 | Upper bank pin inputs |
| pin_out_hi | output | 32 | Upper bank pin levels |
| pin_oe_hi | output | 32 | Upper bank output enables |

## Verification
The bench targets alias writes whose data has 0 bits over register bits that are 1. A design that applied an alias as a plain store would wipe those bits. It also checks that the upper bank's missing bits 16 to 23 stay zero even after all-ones writes and toggles, which an unmasked register would expose. The input sample is checked one edge and two edges after a pin change, which catches a synchroniser with the wrong depth. Back-to-back alias writes, writes to unused operations and alias reads that wrongly return register contents are also covered, with a seeded random mix checked against a bench model.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_WRITE  = 3'd0,
    OP_SET    = 3'd1,
    OP_CLEAR  = 3'd2,
    OP_FLIP   = 3'd3,
    OP_SAMPLE = 3'd4
  } op_e;

  // Ones in bit positions lsb .. lsb+cnt-1.
  function automatic word_t span_mask(int lsb, int cnt);
    word_t m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i >= lsb && i < lsb + cnt) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Implemented bits of the upper bank.
  function automatic word_t upper_mask(int gp_bits);
    return span_mask(0, gp_bits) | span_mask(24, 4) | span_mask(28, 4);
  endfunction

  // True for operations that modify a register.
  function automatic logic is_modify(logic [2:0] op);
    return op <= OP_FLIP;
  endfunction

  // Next register value for a modifying operation.
  function automatic word_t alias_next(word_t cur, word_t wd, logic [2:0] op, word_t mask);
    word_t n;
    case (op)
      OP_WRITE: n = wd;
      OP_SET:   n = cur | wd;
      OP_CLEAR: n = cur & ~wd;
      OP_FLIP:  n = cur ^ wd;
      default:  n = cur;
    endcase
    return n & mask;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_alias_pkg::*;
#(
  parameter word_t MASK = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       reg_sel,
  input  logic [2:0] op,
  input  word_t      wdata,
  output word_t      level_q,
  output word_t      enable_q
);

  // Index 0 is the level register, index 1 the direction register.
  for (genvar g = 0; g < 2; g++) begin : g_reg
    word_t r_q;
    logic  hit;

    assign hit = wr_en && (reg_sel == 1'(g)) && is_modify(op);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r_q <= '0;
      else if (hit) r_q <= alias_next(r_q, wdata, op, MASK);
    end
  end

  assign level_q  = g_reg[0].r_q;
  assign enable_q = g_reg[1].r_q;

endmodule

// File: rtl/gpio_alias_top.sv
module gpio_alias_top
  import gpio_alias_pkg::*;
#(
  parameter int LO_WIDTH    = 32,
  parameter int HI_GP_WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in_lo,
  output logic [31:0] pin_out_lo,
  output logic [31:0] pin_oe_lo,
  input  logic [31:0] pin_in_hi,
  output logic [31:0] pin_out_hi,
  output logic [31:0] pin_oe_hi
);

  localparam word_t LO_MASK = span_mask(0, LO_WIDTH);
  localparam word_t HI_MASK = upper_mask(HI_GP_WIDTH);

  // Address decode, brought out as named wires.
  logic       bank_hi;
  logic       reg_sel;
  logic [2:0] op;
  assign bank_hi = bus_addr[4];
  assign reg_sel = bus_addr[3];
  assign op      = bus_addr[2:0];

  word_t bank_lvl  [2];
  word_t bank_en   [2];
  word_t bank_smp  [2];
  word_t bank_pins [2];

  assign bank_pins[0] = pin_in_lo;
  assign bank_pins[1] = pin_in_hi;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam word_t BMASK = (b == 0) ? LO_MASK : HI_MASK;
    logic  wr_bank;
    word_t smp_raw;

    assign wr_bank = bus_we && (bank_hi == 1'(b));

    gpio_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bank_pins[b]),
      .q     (smp_raw)
    );

    gpio_bank #(.MASK(BMASK)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_bank),
      .reg_sel  (reg_sel),
      .op       (op),
      .wdata    (bus_wdata),
      .level_q  (bank_lvl[b]),
      .enable_q (bank_en[b])
    );

    assign bank_smp[b] = smp_raw & BMASK;
  end

  assign pin_out_lo = bank_lvl[0];
  assign pin_oe_lo  = bank_en[0];
  assign pin_out_hi = bank_lvl[1];
  assign pin_oe_hi  = bank_en[1];

  // Read path: only direct and sample addresses return data.
  always_comb begin
    bus_rdata = '0;
    case (op)
      OP_WRITE:  bus_rdata = reg_sel ? bank_en[bank_hi] : bank_lvl[bank_hi];
      OP_SAMPLE: bus_rdata = reg_sel ? '0 : bank_smp[bank_hi];
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_alias_chk.sv
module gpio_alias_chk
  import gpio_alias_pkg::*;
#(
  parameter int LO_WIDTH    = 32,
  parameter int HI_GP_WIDTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pin_out_lo,
  input logic [31:0] pin_oe_lo,
  input logic [31:0] pin_out_hi,
  input logic [31:0] pin_oe_hi
);

  localparam word_t LO_MASK = span_mask(0, LO_WIDTH);
  localparam word_t HI_MASK = upper_mask(HI_GP_WIDTH);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (pin_out_lo == '0 && pin_oe_lo == '0 && pin_out_hi == '0 && pin_oe_hi == '0));

  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'b00001) |=>
      pin_out_lo == ($past(pin_out_lo) | ($past(bus_wdata) & LO_MASK)));

  // R5
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'b11010) |=>
      pin_oe_hi == ($past(pin_oe_hi) & ~$past(bus_wdata)));

  // R6
  flip_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 5'b01011) |=>
      pin_oe_lo == ($past(pin_oe_lo) ^ ($past(bus_wdata) & LO_MASK)));

  // R7
  alias_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[2:0] inside {3'd1, 3'd2, 3'd3}) |-> bus_rdata == '0);

  // R9
  hi_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out_hi | pin_oe_hi) & ~HI_MASK) == '0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_out_lo) && $stable(pin_oe_lo) &&
                 $stable(pin_out_hi) && $stable(pin_oe_hi)));

endmodule

bind gpio_alias_top gpio_alias_chk #(
  .LO_WIDTH    (LO_WIDTH),
  .HI_GP_WIDTH (HI_GP_WIDTH)
) u_gpio_alias_chk (.*);

// File: tb/test_gpio_alias_top.sv
module test_gpio_alias_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in_lo = '0;
  logic [31:0] pin_out_lo, pin_oe_lo;
  logic [31:0] pin_in_hi = '0;
  logic [31:0] pin_out_hi, pin_oe_hi;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [31:0] m_lvl [2];
  logic [31:0] m_en  [2];

  always #5 clk = ~clk;

  gpio_alias_top i_gpio_alias_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in_lo(pin_in_lo), .pin_out_lo(pin_out_lo), .pin_oe_lo(pin_oe_lo),
    .pin_in_hi(pin_in_hi), .pin_out_hi(pin_out_hi), .pin_oe_hi(pin_oe_hi)
  );

  function automatic logic [31:0] bank_mask(int b);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (b == 0) || (i < 16) || (i >= 24);
    return m;
  endfunction

  function automatic logic [31:0] mdl_op(logic [31:0] cur, logic [31:0] d, int op, int b);
    logic [31:0] n;
    for (int i = 0; i < 32; i++) begin
      if (op == 0)      n[i] = d[i];
      else if (op == 1) n[i] = d[i] ? 1'b1 : cur[i];
      else if (op == 2) n[i] = d[i] ? 1'b0 : cur[i];
      else if (op == 3) n[i] = d[i] ? ~cur[i] : cur[i];
      else              n[i] = cur[i];
    end
    return n & bank_mask(b);
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    int b = a[4];
    if (a[2:0] == 3'd0) return a[3] ? m_en[b] : m_lvl[b];
    if (a[2:0] == 3'd4 && !a[3]) return (b ? pin_in_hi : pin_in_lo) & bank_mask(b);
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic mdl_write(input logic [4:0] a, input logic [31:0] d);
    int b = a[4];
    if (a[2:0] <= 3'd3) begin
      if (a[3]) m_en[b]  = mdl_op(m_en[b],  d, a[2:0], b);
      else      m_lvl[b] = mdl_op(m_lvl[b], d, a[2:0], b);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic check_pins(input string tag);
    check(tag, pin_out_lo, m_lvl[0]);
    check(tag, pin_oe_lo,  m_en[0]);
    check(tag, pin_out_hi, m_lvl[1]);
    check(tag, pin_oe_hi,  m_en[1]);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    for (int b = 0; b < 2; b++) begin m_lvl[b] = '0; m_en[b] = '0; end

    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    check_pins("R1 reset pins");
    bus_addr = 5'b00000; #1 check("R1 reset read", bus_rdata, 32'h0);
    bus_addr = 5'b11000; #1 check("R1 reset read", bus_rdata, 32'h0);
    rst_n = 1'b1;

    // R2 direct level write and readback
    bus_write(5'b00000, 32'hA5A5_0F0F);
    check("R2 pin_out_lo", pin_out_lo, 32'hA5A5_0F0F);
    bus_read(5'b00000, rd); check("R2 readback", rd, 32'hA5A5_0F0F);
    // R3 direction register
    bus_write(5'b01000, 32'h00FF_00FF);
    check("R3 pin_oe_lo", pin_oe_lo, 32'h00FF_00FF);
    bus_read(5'b01000, rd); check("R3 readback", rd, 32'h00FF_00FF);
    // R4 set, R5 clear, R6 toggle
    bus_write(5'b00001, 32'h0000_F0F0);
    check("R4 set", pin_out_lo, 32'hA5A5_FFFF);
    bus_write(5'b00010, 32'h8181_0F00);
    check("R5 clear", pin_out_lo, 32'h2424_F0FF);
    bus_write(5'b01011, 32'hFFFF_0000);
    check("R6 toggle", pin_oe_lo, 32'hFF00_00FF);
    check_pins("R4 R5 R6 model");
    // R7 alias reads return zero
    for (int k = 1; k <= 3; k++) begin
      bus_read(5'(k), rd);          check("R7 alias read", rd, 32'h0);
      bus_read(5'(5'd24 + k), rd);  check("R7 alias read", rd, 32'h0);
    end
    // R11 idle cycles and unused operations change nothing
    @(negedge clk); bus_wdata = 32'hFFFF_FFFF; bus_addr = 5'b00000;
    repeat (3) @(negedge clk);
    check_pins("R11 idle");
    bus_write(5'b00101, 32'hFFFF_FFFF);
    bus_write(5'b00111, 32'hFFFF_FFFF);
    bus_write(5'b01100, 32'hFFFF_FFFF);
    check_pins("R11 unused op");
    // R8 sampled input latency and write ignore
    @(negedge clk); pin_in_lo = 32'h1234_5678; pin_in_hi = 32'hFFFF_FFFF;
    @(negedge clk); bus_addr = 5'b00100; #1 check("R8 after one edge", bus_rdata, 32'h0);
    @(negedge clk); bus_addr = 5'b00100; #1 check("R8 after two edges", bus_rdata, 32'h1234_5678);
    bus_addr = 5'b10100; #1 check("R8 R9 hi sample", bus_rdata, 32'hFF00_FFFF);
    bus_write(5'b00100, 32'hFFFF_FFFF);
    check_pins("R8 sample write ignored");
    // R9 upper bank holes
    bus_write(5'b10000, 32'hFFFF_FFFF);
    check("R9 hi direct", pin_out_hi, 32'hFF00_FFFF);
    bus_write(5'b10011, 32'h00FF_0001);
    check("R9 hi toggle", pin_out_hi, 32'hFF00_FFFE);
    bus_write(5'b11001, 32'h0F0F_0F0F);
    bus_read(5'b11000, rd); check("R9 hi oe read", rd, 32'h0F0F_0F0F & 32'hFF00_FFFF);
    // R10 back-to-back aliases on consecutive edges
    @(negedge clk); bus_we = 1'b1; bus_addr = 5'b00001; bus_wdata = 32'h0000_0003;
    @(negedge clk); check("R10 first alias", pin_out_lo, m_lvl[0] | 32'h3);
    mdl_write(5'b00001, 32'h0000_0003);
    bus_addr = 5'b00011; bus_wdata = 32'h0000_0006;
    @(negedge clk); bus_we = 1'b0;
    mdl_write(5'b00011, 32'h0000_0006);
    check("R10 second alias", pin_out_lo, m_lvl[0]);
    check_pins("R10 model");

    // Seeded random mix against the model (R2 R3 R4 R5 R6 R7 R9 R11)
    for (int it = 0; it < 400; it++) begin
      logic [4:0]  a = 5'($urandom);
      logic [31:0] d = $urandom;
      logic        w = ($urandom % 4) != 0;
      if (it % 25 == 0) begin
        @(negedge clk); pin_in_lo = $urandom; pin_in_hi = $urandom;
        repeat (2) @(negedge clk);
      end
      @(negedge clk);
      bus_addr = a; bus_we = w; bus_wdata = d;
      #1 check("R7 R8 random read", bus_rdata, exp_read(a));
      @(negedge clk);
      bus_we = 1'b0;
      if (w) mdl_write(a, d);
      check_pins("R4 R5 R6 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule